// File: doc/BRIEF.md
# Receive Character Timeout Detector

This block watches a UART receive queue and raises a timeout flag when the queue holds data but no new character has arrived, and software has not read the holding register, for a span of four character times. The span is measured in 16x oversampling ticks. It is rebuilt from the active frame settings: word length, parity enable and stop-bit length. Because a half bit is exactly eight ticks, a stop allowance of one and a half bits is timed without rounding. The flag is meant to feed an interrupt source that prompts software to drain a partly filled queue.

Three states control the block. `ST_IDLE` holds the counter at zero while the queue is empty. The transition IDLE->COUNT is taken when the nonempty flag rises. `ST_COUNT` advances the counter once per tick. It restarts from zero when a character arrives, when the holding register is read, or when the frame settings change. COUNT->EXPIRED is taken on the tick that completes the window. COUNT->IDLE is taken when the queue drains. `ST_EXPIRED` drives the flag. EXPIRED->COUNT is taken on a holding-register read. EXPIRED->IDLE is taken when the queue empties. A separate helper, `rxto_tickgen`, divides the clock by a 16-bit divisor that is loaded as a low byte and a high byte. It is supplied as a tick source for stimulus.

Top module: `rxto_detector`

## Requirements
- R1: The window is 4 × C ticks, where C = 16 × (1 + data bits + parity bit) + stop ticks. `wlen_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. `par_en`=1 adds one parity bit. When a restart or queue fill is driven before clock edge r, the flag first reads high after edge r+W, where W is the window, provided a tick is present every cycle.
- R2: `stop_sel` 0 gives 16 stop ticks. `stop_sel` 1 gives 24 stop ticks (1.5 bits). `stop_sel` 2 and 3 both give 32 stop ticks.
- R3: The count advances only on cycles with `tick_16x` high. With no ticks the flag never rises.
- R4: While `fifo_nonempty` is low the count is held at zero and the flag is low from the following cycle.
- R5: A holding-register read clears a set flag on the next edge and restarts a full window.
- R6: A received-character strobe during counting restarts a full window. It does not clear a flag that is already set.
- R7: Once set, the flag stays high until a holding-register read or until the queue empties. Character strobes and frame changes leave it set.
- R8: A change of any frame setting during counting restarts the count, and the window then uses the new settings.
- R9: A restart strobe in the same cycle as the tick that would complete the window wins. No flag results, and a full new window starts.
- R10: `rxto_tickgen` pulses once every {div_hi, div_lo} clock cycles. A divisor of 0 produces no ticks.
- R11: During and directly after reset the flag is low and the state is `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | 16x oversampling tick, one cycle wide |
| wlen_sel | input | 2 | Data word length select (5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| stop_sel | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2 or 3 = 2 bits |
| fifo_nonempty | input | 1 | Receive queue holds at least one character |
| rx_char_stb | input | 1 | A new character was written to the queue |
| rhr_read_stb | input | 1 | Holding register was read |
| timeout_flag | output | 1 | Character timeout indication |

## Verification
Two functions can fall in the same cycle: the tick that completes the window and a restart strobe. The bench drives the ticks every cycle and waits until exactly one tick is left in the window. It then asserts a holding-register read in that cycle. The check passes only if the flag stays low and next rises a full window after that read edge. A flag that appears one cycle later is counted as a failure.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } rxto_state_e;

    localparam logic [1:0] STOP_ONE      = 2'd0;
    localparam logic [1:0] STOP_ONE_HALF = 2'd1;

    typedef struct packed {
        logic [1:0] wlen_sel;
        logic       par_en;
        logic [1:0] stop_sel;
    } frame_cfg_t;

endpackage

// File: rtl/rxto_window.sv
module rxto_window
    import rxto_pkg::*;
#(
    parameter int TPB   = 16,
    parameter int CHARS = 4,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  frame_cfg_t       cfg,
    output logic [CNT_W-1:0] limit,
    output logic             cfg_changed
);
    localparam int HALF_BIT = TPB / 2;
    localparam int MIN_BITS = 6;

    logic [CNT_W-1:0] word_ticks [4];

    for (genvar g = 0; g < 4; g++) begin : g_wlen
        assign word_ticks[g] = CNT_W'((MIN_BITS + g) * TPB);
    end

    logic [CNT_W-1:0] par_ticks;
    logic [CNT_W-1:0] stop_ticks;
    logic [CNT_W-1:0] char_ticks;

    always_comb begin
        par_ticks = cfg.par_en ? CNT_W'(TPB) : '0;
        unique case (cfg.stop_sel)
            STOP_ONE:      stop_ticks = CNT_W'(TPB);
            STOP_ONE_HALF: stop_ticks = CNT_W'(TPB + HALF_BIT);
            default:       stop_ticks = CNT_W'(2 * TPB);
        endcase
        char_ticks = word_ticks[cfg.wlen_sel] + par_ticks + stop_ticks;
        limit      = CNT_W'(32'(char_ticks) * CHARS);
    end

    frame_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg;
        end
    end

    assign cfg_changed = (cfg != cfg_q);

endmodule

// File: rtl/rxto_ticker.sv
module rxto_ticker #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    assign at_last = (count == limit - CNT_W'(1));

endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
    import rxto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_nonempty,
    input  logic restart,
    input  logic rd_stb,
    input  logic tick,
    input  logic at_last,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic timeout_flag
);
    rxto_state_e state_q;
    rxto_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fifo_nonempty) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!fifo_nonempty) begin
                    state_d = ST_IDLE;
                end else if (!restart && tick && at_last) begin
                    state_d = ST_EXPIRED;
                end
            end
            ST_EXPIRED: begin
                if (!fifo_nonempty) begin
                    state_d = ST_IDLE;
                end else if (rd_stb) begin
                    state_d = ST_COUNT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cnt_clr      = 1'b1;
        cnt_inc      = 1'b0;
        timeout_flag = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                cnt_clr = !fifo_nonempty || restart;
                cnt_inc = fifo_nonempty && !restart && tick;
            end
            ST_EXPIRED: begin
                timeout_flag = 1'b1;
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rxto_tickgen.sv
module rxto_tickgen #(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W/2-1:0] div_lo,
    input  logic [DIV_W/2-1:0] div_hi,
    output logic               tick
);
    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] cnt_q;

    assign divisor = {div_hi, div_lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (divisor == '0) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= divisor - DIV_W'(1)) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/rxto_detector.sv
module rxto_detector
    import rxto_pkg::*;
#(
    parameter int TICKS_PER_BIT    = 16,
    parameter int CHARS_PER_WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_16x,
    input  logic [1:0] wlen_sel,
    input  logic       par_en,
    input  logic [1:0] stop_sel,
    input  logic       fifo_nonempty,
    input  logic       rx_char_stb,
    input  logic       rhr_read_stb,
    output logic       timeout_flag
);
    localparam int MAX_BITS   = 12;
    localparam int MAX_WINDOW = CHARS_PER_WINDOW * TICKS_PER_BIT * MAX_BITS;
    localparam int CNT_W      = $clog2(MAX_WINDOW + 1);

    frame_cfg_t       cfg;
    logic [CNT_W-1:0] win_limit;
    logic [CNT_W-1:0] cnt_val;
    logic             cfg_changed;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             at_last;
    logic             restart;

    assign cfg     = '{wlen_sel: wlen_sel, par_en: par_en, stop_sel: stop_sel};
    assign restart = rx_char_stb || rhr_read_stb || cfg_changed;

    rxto_window #(
        .TPB  (TICKS_PER_BIT),
        .CHARS(CHARS_PER_WINDOW),
        .CNT_W(CNT_W)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .limit      (win_limit),
        .cfg_changed(cfg_changed)
    );

    rxto_ticker #(
        .CNT_W(CNT_W)
    ) u_ticker (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .limit  (win_limit),
        .count  (cnt_val),
        .at_last(at_last)
    );

    rxto_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_nonempty(fifo_nonempty),
        .restart      (restart),
        .rd_stb       (rhr_read_stb),
        .tick         (tick_16x),
        .at_last      (at_last),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .timeout_flag (timeout_flag)
    );

endmodule

// File: rtl/rxto_detector_chk.sv
module rxto_detector_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_16x,
    input logic             fifo_nonempty,
    input logic             rx_char_stb,
    input logic             rhr_read_stb,
    input logic             timeout_flag,
    input logic [CNT_W-1:0] count
);
    // R4
    empty_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty |=> !timeout_flag);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rhr_read_stb |=> !timeout_flag);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_flag) |-> $past(rhr_read_stb || !fifo_nonempty));

    // R3
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(tick_16x));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) && (count != '0) |-> $past(tick_16x));

    // R9
    restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(!rx_char_stb && !rhr_read_stb));

endmodule

bind rxto_detector rxto_detector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_16x     (tick_16x),
    .fifo_nonempty(fifo_nonempty),
    .rx_char_stb  (rx_char_stb),
    .rhr_read_stb (rhr_read_stb),
    .timeout_flag (timeout_flag),
    .count        (cnt_val)
);

// File: tb/tb_rxto_detector.sv
`timescale 1ns/1ps
module tb_rxto_detector;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [7:0] div_lo;
    logic [7:0] div_hi;
    logic [1:0] wlen_sel;
    logic       par_en;
    logic [1:0] stop_sel;
    logic       fifo_nonempty;
    logic       rx_char_stb;
    logic       rhr_read_stb;
    logic       timeout_flag;

    always #4 clk = ~clk;

    rxto_tickgen #(.DIV_W(16)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div_lo(div_lo),
        .div_hi(div_hi),
        .tick  (tick)
    );

    rxto_detector dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_16x     (tick),
        .wlen_sel     (wlen_sel),
        .par_en       (par_en),
        .stop_sel     (stop_sel),
        .fifo_nonempty(fifo_nonempty),
        .rx_char_stb  (rx_char_stb),
        .rhr_read_stb (rhr_read_stb),
        .timeout_flag (timeout_flag)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    edge_cnt = 0;
    logic  flag_prev = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // window from the requirements: 4 chars of 16-tick bits plus stop ticks
    function automatic int win(input int wl, input int par, input int stp);
        int stop_t;
        stop_t = (stp == 0) ? 16 : (stp == 1) ? 24 : 32;
        return 4 * (16 * (1 + 5 + wl + par) + stop_t);
    endfunction

    // driver side: restart the edge count and queue the expected rise edge
    task automatic arm_expect(input int w, input string tag);
        edge_cnt = 0;
        exp_q.delete();
        tag_q.delete();
        exp_q.push_back(w + 1);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each flag rise against the scoreboard
    always @(posedge clk) begin
        #2;
        edge_cnt++;
        if (rst_n && timeout_flag && !flag_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected rise", edge_cnt, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(edge_cnt == e, t, edge_cnt, e);
            end
        end
        flag_prev = timeout_flag;
    end

    task automatic wait_flag(input int max_cycles);
        int n;
        n = 0;
        while (!timeout_flag && n < max_cycles) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_window(input int wl, input int par, input int stp, input string tag);
        fifo_nonempty = 1'b0;
        wlen_sel = 2'(wl);
        par_en   = 1'(par);
        stop_sel = 2'(stp);
        repeat (3) @(negedge clk);
        arm_expect(win(wl, par, stp), tag);
        fifo_nonempty = 1'b1;
        wait_flag(win(wl, par, stp) + 20);
        check(timeout_flag == 1'b1, tag, timeout_flag, 1);
    endtask

    task automatic pulse_read();
        rhr_read_stb = 1'b1;
        @(negedge clk);
        rhr_read_stb = 1'b0;
    endtask

    task automatic measure_period(input int div, input string tag);
        int gap;
        div_lo = div[7:0];
        div_hi = div[15:8];
        repeat (2 * div + 4) @(negedge clk);
        while (!tick) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!tick && gap < 70000);
        check(gap == div, tag, gap, div);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        div_lo = 8'd1;
        div_hi = 8'd0;
        wlen_sel = 2'd0;
        par_en = 1'b0;
        stop_sel = 2'd0;
        fifo_nonempty = 1'b0;
        rx_char_stb = 1'b0;
        rhr_read_stb = 1'b0;
        repeat (4) @(negedge clk);
        check(timeout_flag == 1'b0, "R11 in reset", timeout_flag, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(timeout_flag == 1'b0, "R11 after reset", timeout_flag, 0);

        // R1 / R2 windows for several frame formats
        run_window(0, 0, 0, "R1 5N1");
        run_window(3, 1, 2, "R1 8P2");
        run_window(0, 0, 1, "R2 5N1.5");
        run_window(2, 1, 0, "R1 7P1");
        run_window(1, 0, 3, "R2 6N2 code3");

        // R7: flag holds through time, characters and frame changes
        repeat (40) @(negedge clk);
        check(timeout_flag == 1'b1, "R7 hold", timeout_flag, 1);
        rx_char_stb = 1'b1;
        @(negedge clk);
        rx_char_stb = 1'b0;
        @(negedge clk);
        check(timeout_flag == 1'b1, "R6 char keeps flag", timeout_flag, 1);
        par_en = 1'b1;
        repeat (2) @(negedge clk);
        check(timeout_flag == 1'b1, "R7 cfg keeps flag", timeout_flag, 1);
        par_en = 1'b0;
        repeat (2) @(negedge clk);

        // R5: read clears and restarts a full window
        rhr_read_stb = 1'b1;
        arm_expect(win(1, 0, 3), "R5 rewindow");
        @(negedge clk);
        rhr_read_stb = 1'b0;
        check(timeout_flag == 1'b0, "R5 clear", timeout_flag, 0);
        wait_flag(700);
        check(timeout_flag == 1'b1, "R5 reexpire", timeout_flag, 1);

        // R4: queue empty clears flag and holds timer
        fifo_nonempty = 1'b0;
        @(negedge clk);
        check(timeout_flag == 1'b0, "R4 clear", timeout_flag, 0);
        repeat (900) @(negedge clk);
        check(timeout_flag == 1'b0, "R4 held", timeout_flag, 0);

        // R6: new character restarts the count mid-window
        wlen_sel = 2'd0;
        par_en = 1'b0;
        stop_sel = 2'd0;
        repeat (2) @(negedge clk);
        arm_expect(win(0, 0, 0), "R6 first");
        fifo_nonempty = 1'b1;
        repeat (300) @(negedge clk);
        rx_char_stb = 1'b1;
        arm_expect(win(0, 0, 0), "R6 restart");
        @(negedge clk);
        rx_char_stb = 1'b0;
        wait_flag(600);
        check(timeout_flag == 1'b1, "R6 expire", timeout_flag, 1);

        // R8: frame change mid-count restarts with the new window
        rhr_read_stb = 1'b1;
        arm_expect(win(0, 0, 0), "R8 pre");
        @(negedge clk);
        rhr_read_stb = 1'b0;
        repeat (200) @(negedge clk);
        wlen_sel = 2'd3;
        par_en = 1'b1;
        stop_sel = 2'd2;
        arm_expect(win(3, 1, 2), "R8 new window");
        wait_flag(900);
        check(timeout_flag == 1'b1, "R8 expire", timeout_flag, 1);

        // R9: read in the same cycle as the completing tick
        rhr_read_stb = 1'b1;
        arm_expect(win(3, 1, 2), "R9 pre");
        @(negedge clk);
        rhr_read_stb = 1'b0;
        while (edge_cnt < win(3, 1, 2)) @(negedge clk);
        rhr_read_stb = 1'b1;
        arm_expect(win(3, 1, 2), "R9 restart wins");
        @(negedge clk);
        rhr_read_stb = 1'b0;
        check(timeout_flag == 1'b0, "R9 no flag", timeout_flag, 0);
        wait_flag(900);
        check(timeout_flag == 1'b1, "R9 expire", timeout_flag, 1);

        // R3: no ticks, no timeout
        fifo_nonempty = 1'b0;
        div_lo = 8'd0;
        repeat (4) @(negedge clk);
        exp_q.delete();
        tag_q.delete();
        fifo_nonempty = 1'b1;
        repeat (1000) @(negedge clk);
        check(timeout_flag == 1'b0, "R3 no tick", timeout_flag, 0);
        fifo_nonempty = 1'b0;
        @(negedge clk);

        // R10: divisor helper
        measure_period(5, "R10 div5");
        measure_period(258, "R10 div258");
        begin
            int seen;
            div_lo = 8'd0;
            div_hi = 8'd0;
            repeat (3) @(negedge clk);
            seen = 0;
            repeat (50) begin
                @(negedge clk);
                if (tick) seen++;
            end
            check(seen == 0, "R10 div0", seen, 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule